// File: doc/BRIEF.md
# Interrupt Request and Vector Unit

This block collects three interrupt sources (a timer-3 overflow, a timer-4 overflow and a keyboard strobe) into a register of pending cells. It raises an interrupt request toward the instruction sequencer whenever a cell is pending, the global inhibit flag is clear and the processor is not already inside an interrupt routine. Each source has a fixed interrupt number: timer 3 is number 3, timer 4 is number 4 and the keyboard is number 5. The unit always presents the jump-table address of the winning source. That address is the base octal 04000 plus the interrupt number shifted left by two.

The sequencer takes the interrupt with a one-cycle strobe. From then on the unit holds the number of the source being serviced. A reset-priority command at the end of the routine drops that source's cell. A separate clear command empties every cell. The inhibit flag is set and cleared by two decoded transfer-control targets: a transfer to address 4 sets it and a transfer to address 3 clears it. Both reach the block as one-cycle pulses.

The controller has two states. In IDLE the unit is ready and advertises the current winner. In SERVE one source is being serviced. The transitions are: IDLE to SERVE on a take strobe while the request is raised (TAKE); SERVE to IDLE on a reset-priority command (RELEASE); SERVE to IDLE on a clear-cell command (FLUSH). Every other case stays in the current state.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the request output is 0, the vector is 0, no cell is pending, inhibit is clear and the state is IDLE.
- R2: Each source sets its cell on the clock edge where its input is first seen high (rising edge). A strobe held high for several cycles sets the cell only once, so clearing the cell while the strobe is still high leaves the cell empty.
- R3: The vector for interrupt number n is 16'o04000 + (n << 2). Timer 3 (n=3) gives 16'o04014, timer 4 (n=4) gives 16'o04020 and the keyboard (n=5) gives 16'o04024.
- R4: When several cells are pending, the lowest interrupt number wins.
- R5: In IDLE the vector shows the winning pending source, or 0 when no cell is pending. The request output is 1 exactly when the state is IDLE, a cell is pending, inhibit is clear and in_rupt_i is 0.
- R6: inh_set_i sets the inhibit flag and inh_clr_i clears it. When both arrive in the same cycle, set wins. While inhibit is set no request is raised, but cells stay latched and the request appears once inhibit is cleared.
- R7: A take strobe while the request is 1 enters SERVE (TAKE). In SERVE the request output is 0 and the vector holds the taken source's vector. A take strobe while the request is 0 has no effect.
- R8: A reset-priority command in SERVE clears only the serviced source's cell and returns to IDLE (RELEASE). Other pending cells remain.
- R9: A clear-cell command empties all cells and returns to IDLE (FLUSH). A source rising edge in the same cycle is still latched.
- R10: While in_rupt_i is 1 no request is raised. The output follows in_rupt_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_t3_i | input | 1 | Timer 3 overflow strobe |
| req_t4_i | input | 1 | Timer 4 overflow strobe |
| req_kbd_i | input | 1 | Keyboard strobe |
| inh_set_i | input | 1 | Decoded transfer to address 4: set inhibit |
| inh_clr_i | input | 1 | Decoded transfer to address 3: clear inhibit |
| take_i | input | 1 | Sequencer takes the interrupt |
| krst_i | input | 1 | Reset priority of the serviced source |
| clr_cell_i | input | 1 | Empty all pending cells |
| in_rupt_i | input | 1 | Processor is inside an interrupt routine |
| irq_o | output | 1 | Interrupt request |
| vector_o | output | 16 | Jump-table address |

## Verification
A source edge, take, reset-priority, clear-cell or inhibit command is captured by the clock edge that samples it. Its effect on irq_o and vector_o is therefore visible just after that same edge. A change of in_rupt_i affects irq_o combinationally, with no edge in between. The bench drives inputs shortly after a rising edge and checks one time unit after the next rising edge. For in_rupt_i it checks without an intervening edge, so each result is sampled in the cycle it becomes due.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } irqv_state_e;
endpackage

// File: rtl/irqv_edge.sv
module irqv_edge #(
    parameter int N_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    output logic [N_SRC-1:0] rise_o
);
    logic [N_SRC-1:0] prev_q;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= req_i[g];
        end
        assign rise_o[g] = req_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
    parameter int N_SRC = 3,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] cell_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cell_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |cell_i;
    end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
    import irqv_pkg::*;
#(
    parameter int N_SRC = 3,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] rise_i,
    input  logic             any_i,
    input  logic [IDX_W-1:0] win_idx_i,
    input  logic             inh_set_i,
    input  logic             inh_clr_i,
    input  logic             take_i,
    input  logic             krst_i,
    input  logic             clr_cell_i,
    input  logic             in_rupt_i,
    output logic [N_SRC-1:0] cell_o,
    output logic             inh_o,
    output logic             serving_o,
    output logic [IDX_W-1:0] cur_idx_o,
    output logic             irq_o
);
    irqv_state_e      state_q, state_d;
    logic [N_SRC-1:0] cell_q, cell_d;
    logic             inh_q, inh_d;
    logic [IDX_W-1:0] cur_q, cur_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cell_q  <= '0;
            inh_q   <= 1'b0;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            cell_q  <= cell_d;
            inh_q   <= inh_d;
            cur_q   <= cur_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        cell_d  = cell_q;
        irq_o   = 1'b0;
        inh_d   = inh_set_i ? 1'b1 : (inh_clr_i ? 1'b0 : inh_q);
        unique case (state_q)
            ST_IDLE: begin
                irq_o = any_i & ~inh_q & ~in_rupt_i;
                if (clr_cell_i) begin
                    cell_d = '0;
                end else if (take_i && irq_o) begin
                    state_d = ST_SERVE;
                    cur_d   = win_idx_i;
                end
            end
            ST_SERVE: begin
                if (clr_cell_i) begin
                    cell_d  = '0;
                    state_d = ST_IDLE;
                end else if (krst_i) begin
                    cell_d[cur_q] = 1'b0;
                    state_d       = ST_IDLE;
                end
            end
        endcase
        cell_d = cell_d | rise_i;
    end

    assign cell_o    = cell_q;
    assign inh_o     = inh_q;
    assign serving_o = (state_q == ST_SERVE);
    assign cur_idx_o = cur_q;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
    parameter int          N_SRC     = 3,
    parameter int          FIRST_NUM = 3,
    parameter int          VEC_SHIFT = 2,
    parameter logic [15:0] VEC_BASE  = 16'o04000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_t3_i,
    input  logic        req_t4_i,
    input  logic        req_kbd_i,
    input  logic        inh_set_i,
    input  logic        inh_clr_i,
    input  logic        take_i,
    input  logic        krst_i,
    input  logic        clr_cell_i,
    input  logic        in_rupt_i,
    output logic        irq_o,
    output logic [15:0] vector_o
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0] req_w, rise_w, cell_q;
    logic             any_w, inh_q, serving_w;
    logic [IDX_W-1:0] win_idx_w, cur_idx_w, sel_idx_w;

    assign req_w = {req_kbd_i, req_t4_i, req_t3_i};

    irqv_edge #(.N_SRC(N_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_w),
        .rise_o (rise_w)
    );

    irqv_prio #(.N_SRC(N_SRC)) u_prio (
        .cell_i (cell_q),
        .any_o  (any_w),
        .idx_o  (win_idx_w)
    );

    irqv_ctrl #(.N_SRC(N_SRC)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise_w),
        .any_i      (any_w),
        .win_idx_i  (win_idx_w),
        .inh_set_i  (inh_set_i),
        .inh_clr_i  (inh_clr_i),
        .take_i     (take_i),
        .krst_i     (krst_i),
        .clr_cell_i (clr_cell_i),
        .in_rupt_i  (in_rupt_i),
        .cell_o     (cell_q),
        .inh_o      (inh_q),
        .serving_o  (serving_w),
        .cur_idx_o  (cur_idx_w),
        .irq_o      (irq_o)
    );

    assign sel_idx_w = serving_w ? cur_idx_w : win_idx_w;

    always_comb begin
        if (serving_w || any_w)
            vector_o = VEC_BASE + ((16'(FIRST_NUM) + 16'(sel_idx_w)) << VEC_SHIFT);
        else
            vector_o = '0;
    end
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        take_i,
    input logic        inh_set_i,
    input logic        clr_cell_i,
    input logic        in_rupt_i,
    input logic        irq_o,
    input logic [15:0] vector_o,
    input logic [2:0]  cell_q,
    input logic [2:0]  rise_w,
    input logic        inh_q
);
    p_take_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && irq_o) |=> (!irq_o && $stable(vector_o)));

    p_inhibit_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inh_q |-> !irq_o);

    p_inhibit_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        inh_set_i |=> inh_q);

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cell_i |=> ((cell_q & ~$past(rise_w)) == 3'b000));

    p_vector_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vector_o[1:0] == 2'b00 && (vector_o & ~16'o00177) == 16'o04000));

    p_in_rupt_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_rupt_i |-> !irq_o);
endmodule

bind irq_vector_unit irqv_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take_i),
    .inh_set_i  (inh_set_i),
    .clr_cell_i (clr_cell_i),
    .in_rupt_i  (in_rupt_i),
    .irq_o      (irq_o),
    .vector_o   (vector_o),
    .cell_q     (cell_q),
    .rise_w     (rise_w),
    .inh_q      (inh_q)
);

// File: tb/tb_irq_vector_unit.sv
`timescale 1ns/1ps
module tb_irq_vector_unit;
    localparam logic [15:0] V3 = 16'o04014;
    localparam logic [15:0] V4 = 16'o04020;
    localparam logic [15:0] V5 = 16'o04024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_t3_i = 0, req_t4_i = 0, req_kbd_i = 0;
    logic inh_set_i = 0, inh_clr_i = 0, take_i = 0, krst_i = 0;
    logic clr_cell_i = 0, in_rupt_i = 0;
    logic        irq_o;
    logic [15:0] vector_o;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_vector_unit dut (
        .clk(clk), .rst_n(rst_n),
        .req_t3_i(req_t3_i), .req_t4_i(req_t4_i), .req_kbd_i(req_kbd_i),
        .inh_set_i(inh_set_i), .inh_clr_i(inh_clr_i), .take_i(take_i),
        .krst_i(krst_i), .clr_cell_i(clr_cell_i), .in_rupt_i(in_rupt_i),
        .irq_o(irq_o), .vector_o(vector_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0o expected %0o", tag, act, exp);
        end
    endtask

    task automatic pulse_req(bit t3, bit t4, bit kb);
        req_t3_i = t3; req_t4_i = t4; req_kbd_i = kb;
        step();
        req_t3_i = 0; req_t4_i = 0; req_kbd_i = 0;
    endtask

    task automatic do_take();
        take_i = 1; step(); take_i = 0;
    endtask

    task automatic do_krst();
        krst_i = 1; step(); krst_i = 0;
    endtask

    task automatic t_reset();
        chk("R1 irq", 16'(irq_o), 16'd0);
        chk("R1 vector", vector_o, 16'd0);
        do_take();
        chk("R7 take ignored when idle", 16'(irq_o), 16'd0);
    endtask

    task automatic t_single();
        pulse_req(0, 0, 1);
        chk("R2 kbd latched irq", 16'(irq_o), 16'd1);
        chk("R3 kbd vector", vector_o, V5);
        do_take();
        chk("R7 irq low in serve", 16'(irq_o), 16'd0);
        chk("R7 vector held", vector_o, V5);
        do_krst();
        chk("R8 release irq", 16'(irq_o), 16'd0);
        chk("R5 vector zero when empty", vector_o, 16'd0);
    endtask

    task automatic t_held_strobe();
        req_t4_i = 1;
        step();
        chk("R3 t4 vector", vector_o, V4);
        do_take();
        do_krst();
        step();
        chk("R2 held strobe latched once irq", 16'(irq_o), 16'd0);
        chk("R2 held strobe latched once vec", vector_o, 16'd0);
        req_t4_i = 0;
        step();
    endtask

    task automatic t_priority();
        pulse_req(1, 1, 1);
        chk("R4 t3 wins", vector_o, V3);
        do_take();
        do_krst();
        chk("R8 others remain irq", 16'(irq_o), 16'd1);
        chk("R4 t4 next", vector_o, V4);
        do_take();
        do_krst();
        chk("R4 kbd last", vector_o, V5);
        do_take();
        do_krst();
        chk("R5 all serviced", vector_o, 16'd0);
    endtask

    task automatic t_inhibit();
        inh_set_i = 1; step(); inh_set_i = 0;
        pulse_req(1, 0, 0);
        chk("R6 inhibit blocks", 16'(irq_o), 16'd0);
        chk("R5 vector shows winner while inhibited", vector_o, V3);
        do_take();
        inh_clr_i = 1; step(); inh_clr_i = 0;
        chk("R6 latched after clear", 16'(irq_o), 16'd1);
        chk("R7 ignored take left idle", vector_o, V3);
        inh_set_i = 1; inh_clr_i = 1; step(); inh_set_i = 0; inh_clr_i = 0;
        chk("R6 set wins", 16'(irq_o), 16'd0);
        inh_clr_i = 1; step(); inh_clr_i = 0;
        chk("R6 cleared again", 16'(irq_o), 16'd1);
    endtask

    task automatic t_in_rupt();
        in_rupt_i = 1; #1;
        chk("R10 in_rupt blocks", 16'(irq_o), 16'd0);
        in_rupt_i = 0; #1;
        chk("R10 released", 16'(irq_o), 16'd1);
    endtask

    task automatic t_flush();
        pulse_req(0, 1, 0);
        do_take();
        chk("R7 t3 taken", vector_o, V3);
        clr_cell_i = 1; step(); clr_cell_i = 0;
        chk("R9 flush irq", 16'(irq_o), 16'd0);
        chk("R9 flush vector", vector_o, 16'd0);
        pulse_req(1, 0, 0);
        clr_cell_i = 1; req_kbd_i = 1; step(); clr_cell_i = 0; req_kbd_i = 0;
        chk("R9 same-cycle edge survives", vector_o, V5);
        chk("R9 same-cycle edge irq", 16'(irq_o), 16'd1);
        clr_cell_i = 1; step(); clr_cell_i = 0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_single();
        t_held_strobe();
        t_priority();
        t_inhibit();
        t_in_rupt();
        t_flush();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule